// File: doc/BRIEF.md
# Receive Byte-to-Halfword Frame Packer

This block sits on the receive path between a byte-wide frame source and a 16-bit client bus. Bytes arrive one per byte-clock cycle while a frame is in progress. The block pairs them into halfwords and presents each halfword for one client cycle. The client clock is the divide-by-two of the byte clock. Its rising edge falls on the byte edges that close the odd-numbered byte cycles after reset, where the first cycle after reset is cycle 0. Every output register changes only on those edges. The source must start each frame on an even byte cycle, so byte pairing begins with the first byte of the frame.

Frames may hold an even or an odd number of bytes. When the count is odd, the final client word carries a single byte on the low lane, and the upper-lane valid drops one client cycle ahead of the word valid. The source gives end-of-frame status as a one-byte-cycle pulse on a good or bad input. It can do so at any point from the first cycle after the last byte until the client edge that closes the first idle client cycle. The block holds that status and replays it as a single pulse one client cycle after the word valid has fallen.

Top module: `rx_halfword_packer`

## Requirements
- R1: Within each client word, the frame byte received first sits on bits [7:0] and the byte received second on bits [15:8]. Words leave in arrival order, one per client cycle.
- R2: For an even-length frame, the word valid and the upper-byte valid rise on the same client edge and fall on the same client edge.
- R3: For an odd-length frame, the last client word carries the final byte on bits [7:0] with the word valid high and the upper-byte valid low. The word valid then falls on the next client edge.
- R4: When the word valid is high and the upper-byte valid is low, bits [15:8] are zero. When the word valid is low, the whole data output is zero.
- R5: For each frame, exactly one of the good and bad outputs pulses high for one client cycle. The pulse comes in the client cycle right after the first idle client cycle that follows the frame's last word. If a bad indication was received for the frame, the pulse is on the bad output, even if a good indication was also received.
- R6: The good and bad outputs are never high in the same cycle.
- R7: No output changes on a byte edge that closes an even-numbered byte cycle.
- R8: A synchronous active-high reset clears all outputs and any partly formed word or held status, and restarts the byte-cycle numbering at 0.
- R9: The upper-byte valid is never high while the word valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkByte | input | 1 | Byte-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| rxData | input | 8 | Received frame byte |
| rxValid | input | 1 | High while rxData carries a frame byte |
| rxGood | input | 1 | One-cycle end-of-frame good indication |
| rxBad | input | 1 | One-cycle end-of-frame bad indication |
| cliData | output | 16 | Packed client word |
| cliValid | output | 1 | Client word valid |
| cliValidHi | output | 1 | Upper byte of cliData valid |
| cliGood | output | 1 | Frame-good pulse, one client cycle |
| cliBad | output | 1 | Frame-bad pulse, one client cycle |

## Verification
A stale or missing half-word holding flag shows up at the ports on the very next client edge. It appears as swapped or duplicated bytes, or as a spurious lone-byte word with the upper valid low. A wrong end-of-frame flag shows up two client cycles after the last word, as a missing, doubled or early status pulse. A phase error shows up within one byte cycle, as an output that moves on a byte edge where it must hold. The bench compares every output at every byte cycle, so each of these faults is caught within at most four byte cycles of its cause.

// File: rtl/rxpack_pkg.sv
package rxpack_pkg;

  typedef struct packed {
    logic tick;       // this byte edge is a client edge
    logic loadLow;    // capture the first byte of a pair
    logic emitPair;   // present a full two-byte word
    logic emitLone;   // present a single trailing low byte
    logic emitGood;   // pulse frame-good
    logic emitBad;    // pulse frame-bad
  } packCtl_t;

endpackage

// File: rtl/rxpack_ctrl.sv
module rxpack_ctrl
  import rxpack_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rxValid,
  input  logic     rxGood,
  input  logic     rxBad,
  output packCtl_t ctl
);

  logic phase;      // 1 on byte cycles whose closing edge is a client edge
  logic haveLow;    // a first byte of a pair is held
  logic wasValid;   // a word was presented in the current client cycle
  logic endSeen;    // current client cycle is the first idle one after a frame
  logic pendGood;
  logic pendBad;

  logic wordNow;
  logic badAny;
  logic goodAny;

  always_comb begin
    wordNow      = phase && haveLow;
    badAny       = pendBad || rxBad;
    goodAny      = pendGood || rxGood;
    ctl.tick     = phase;
    ctl.loadLow  = !phase && rxValid;
    ctl.emitPair = wordNow && rxValid;
    ctl.emitLone = wordNow && !rxValid;
    ctl.emitBad  = phase && endSeen && badAny;
    ctl.emitGood = phase && endSeen && !badAny && goodAny;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      haveLow  <= 1'b0;
      wasValid <= 1'b0;
      endSeen  <= 1'b0;
      pendGood <= 1'b0;
      pendBad  <= 1'b0;
    end else begin
      phase <= !phase;
      if (ctl.loadLow)
        haveLow <= 1'b1;
      else if (phase)
        haveLow <= 1'b0;
      if (phase && endSeen) begin
        pendGood <= 1'b0;
        pendBad  <= 1'b0;
      end else begin
        pendGood <= pendGood || rxGood;
        pendBad  <= pendBad || rxBad;
      end
      if (phase) begin
        wasValid <= wordNow;
        endSeen  <= wasValid && !wordNow;
      end
    end
  end

  // R5: a status pulse is only issued in a client cycle whose predecessor was idle
  assert_status_after_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.emitGood || ctl.emitBad) |-> !wasValid);

  // R7: client edges alternate with non-client edges
  assert_phase_alternates_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.tick |=> !ctl.tick);

endmodule

// File: rtl/rxpack_dp.sv
module rxpack_dp
  import rxpack_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rxData,
  input  packCtl_t          ctl,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              outHi,
  output logic              outGood,
  output logic              outBad
);

  logic [BYTE_W-1:0] lowHold;
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    if (ctl.emitPair)
      nextWord = {rxData, lowHold};
    else if (ctl.emitLone)
      nextWord = {{BYTE_W{1'b0}}, lowHold};
    else
      nextWord = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      lowHold <= '0;
    else if (ctl.loadLow)
      lowHold <= rxData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
      outHi    <= 1'b0;
      outGood  <= 1'b0;
      outBad   <= 1'b0;
    end else if (ctl.tick) begin
      outData  <= nextWord;
      outValid <= ctl.emitPair || ctl.emitLone;
      outHi    <= ctl.emitPair;
      outGood  <= ctl.emitGood;
      outBad   <= ctl.emitBad;
    end
  end

  assert_hi_needs_word_R9: assert property (@(posedge clk) disable iff (rst)
    outHi |-> outValid);

  assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(outGood && outBad));

  assert_lone_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outHi) |-> (outData[WORD_W-1:BYTE_W] == '0));

  assert_hold_off_edge_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl.tick |=> $stable({outData, outValid, outHi, outGood, outBad}));

endmodule

// File: rtl/rx_halfword_packer.sv
module rx_halfword_packer
  import rxpack_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clkByte,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              rxGood,
  input  logic              rxBad,
  output logic [WORD_W-1:0] cliData,
  output logic              cliValid,
  output logic              cliValidHi,
  output logic              cliGood,
  output logic              cliBad
);

  packCtl_t ctl;

  rxpack_ctrl u_ctrl (
    .clk     (clkByte),
    .rst     (rst),
    .rxValid (rxValid),
    .rxGood  (rxGood),
    .rxBad   (rxBad),
    .ctl     (ctl)
  );

  rxpack_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clkByte),
    .rst      (rst),
    .rxData   (rxData),
    .ctl      (ctl),
    .outData  (cliData),
    .outValid (cliValid),
    .outHi    (cliValidHi),
    .outGood  (cliGood),
    .outBad   (cliBad)
  );

endmodule

// File: tb/tb_rx_halfword_packer.sv
module tb_rx_halfword_packer;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  rxData;
  logic        rxValid, rxGood, rxBad;
  logic [15:0] cliData;
  logic        cliValid, cliValidHi, cliGood, cliBad;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz byte clock

  rx_halfword_packer dut (
    .clkByte(clk), .rst(rst), .rxData(rxData), .rxValid(rxValid),
    .rxGood(rxGood), .rxBad(rxBad), .cliData(cliData), .cliValid(cliValid),
    .cliValidHi(cliValidHi), .cliGood(cliGood), .cliBad(cliBad)
  );

  // vector table: frame length, byte seed, status code (0 good, 1 bad, 2 both)
  localparam int NV = 8;
  localparam int LEN_T [NV] = '{1, 2, 3, 7, 8, 5, 64, 4};
  localparam int SEED_T[NV] = '{8'h11, 8'hA0, 8'h3C, 8'h77, 8'h05, 8'hE2, 8'h19, 8'hF0};
  localparam int ST_T  [NV] = '{0, 1, 0, 1, 0, 2, 0, 2};

  function automatic logic [7:0] bv(input int seed, input int i);
    return 8'(seed + i * 37 + (i >> 3));
  endfunction

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {valid,hi,good,bad,data} actual %h expected %h at %0t",
               tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] actual();
    return {cliValid, cliValidHi, cliGood, cliBad, cliData};
  endfunction

  // check outputs after the edge closing byte cycle e of a frame
  task automatic sampleCheck(input int e, input int len, input int seed,
                             input int st, input int last);
    int t;
    int k;
    logic [19:0] exp;
    string tag;
    t   = (e % 2 == 1) ? e : e - 1;
    exp = '0;
    tag = "R4 idle";
    if (t >= 1) begin
      k = (t - 1) / 2;
      if (k <= last) begin
        if (2 * k + 1 < len) begin
          exp = {1'b1, 1'b1, 1'b0, 1'b0, bv(seed, 2 * k + 1), bv(seed, 2 * k)};
          tag = (len % 2 == 0) ? "R2 R9 even pair" : "R1 pair order";
        end else begin
          exp = {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, bv(seed, 2 * k)};
          tag = "R3 R4 lone byte";
        end
      end else if (k == last + 2) begin
        exp = {1'b0, 1'b0, (st == 0), (st != 0), 16'h0000};
        tag = "R5 R6 status pulse";
      end
    end
    if (e % 2 == 0) tag = {"R7 hold ", tag};
    chk(tag, actual(), exp);
  endtask

  // must be called at a negedge that precedes an even byte cycle
  task automatic runFrame(input int len, input int seed, input int st);
    int last;
    int n;
    last = (len + 1) / 2 - 1;
    n    = 2 * (last + 5);
    for (int c = 0; c <= n; c++) begin
      if (c > 0) begin
        @(negedge clk);
        sampleCheck(c - 1, len, seed, st, last);
      end
      if (c < n) begin
        rxValid = (c < len);
        rxData  = (c < len) ? bv(seed, c) : 8'h00;
        rxGood  = (c == len) && (st == 0 || st == 2);
        rxBad   = (c == len) && (st != 0);
      end
    end
    rxValid = 1'b0; rxGood = 1'b0; rxBad = 1'b0; rxData = 8'h00;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rxValid = 1'b0; rxGood = 1'b0; rxBad = 1'b0; rxData = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 reset state", actual(), 20'h0);
    rst = 1'b0;

    // table walk: R1..R7, R9
    for (int v = 0; v < NV; v++)
      runFrame(LEN_T[v], SEED_T[v], ST_T[v]);

    // R8: reset in the middle of a frame, with a half word held
    rxValid = 1'b1; rxData = 8'hAA;
    @(negedge clk); rxData = 8'hBB;
    @(negedge clk); rxData = 8'hCC;
    @(negedge clk); rst = 1'b1; rxData = 8'hDD; rxBad = 1'b1;
    @(negedge clk);
    chk("R8 mid-frame reset clears outputs", actual(), 20'h0);
    rst = 1'b0; rxValid = 1'b0; rxBad = 1'b0; rxData = 8'h00;

    // after reset: no leftover low byte or held bad status
    runFrame(1, 8'h5A, 0);
    runFrame(6, 8'h42, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule